// File: doc/BRIEF.md
# Interleaved Multi-Bank Memory Controller

This block takes word-addressed read and write requests on a valid/ready port and spreads them over several independent memory banks. A combinational address mapper picks the target bank. In plain mode the bank is the low address bits, so a sequential stream visits every bank in turn. In permuted mode the bank field is XORed with a slice of low tag bits taken above a cache-index boundary, so addresses that a set-indexed cache would place on one set end up in different banks. In permuted mode an address keeps its page and its offset inside the bank.

Each bank keeps one open row. A read or write to the open row is a hit and occupies the bank for one cycle. Any other access is a miss and occupies it for a parameterised number of cycles. Banks work in parallel, so a request stalls only when its own bank is occupied, refreshing, has a refresh waiting, or still holds an undelivered read. A per-bank refresh request blocks that bank for a fixed number of cycles once it is idle, and it closes the open row. Read data leaves through a valid/ready response port in request order. Per-bank hit and miss counters are brought out as ports.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: With `mode_perm_i` low, word address `a` is served by bank `a mod N_BANKS` (bits [1:0] at defaults).
- R2: With `mode_perm_i` high, the bank is `a[1:0] XOR a[8:7]` (TAG_LSB = 7). All addresses that share row bits `a[9:5]` and bits `a[1:0]` therefore stay in one bank and one row.
- R3: A read to a bank's open row raises `rsp_valid_o` in the cycle after acceptance, and that bank can accept again in the next cycle.
- R4: A read to a bank with no open row or a different row raises `rsp_valid_o` MISS_LAT (4) cycles after acceptance. The bank refuses requests until its data is ready.
- R5: A request to an idle bank is accepted while other banks are busy. A request to a busy bank is held with `req_ready_o` low.
- R6: A one-cycle pulse on `refresh_req_i[b]` blocks bank `b` for REF_LAT (6) cycles once its current access ends, and it closes the open row. The next access to that bank is a miss, and the bank's data is kept.
- R7: Read data returns in acceptance order. A response held by low `rsp_ready_i` keeps valid high and its data stable.
- R8: Writes follow the same hit and miss occupancy as reads and produce no response. A later read returns the written word.
- R9: `hit_cnt_o` and `miss_cnt_o` hold a 16-bit count per bank, with bank `b` at bits `[16*b +: 16]`. Each accepted request adds one to the matching count. Reset clears them.
- R10: Four reads at stride 128 starting at 0 all land in bank 0 in plain mode, and land in four different banks in permuted mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_perm_i | input | 1 | 1 selects permuted bank mapping; change only while idle |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Target bank can take the request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (10) | Word address |
| req_wdata_i | input | DATA_W (16) | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_ready_i | input | 1 | Consumer takes read data |
| rsp_rdata_o | output | DATA_W (16) | Read data |
| refresh_req_i | input | N_BANKS (4) | Per-bank refresh request pulse |
| hit_cnt_o | output | N_BANKS*CNT_W (64) | Per-bank row-hit counts |
| miss_cnt_o | output | N_BANKS*CNT_W (64) | Per-bank row-miss counts |

## Verification
A behavioural model in the bench predicts `req_ready_o`, `rsp_valid_o` and the read data on every cycle. The stimulus is a sequential stream, which shows the rotation over banks and the row-hit runs, and single isolated reads, which separate hit latency from miss latency. A stride-128 stream is run in both mapping modes, so plain and permuted bank selection give visibly different counter spreads. A long random mix with response backpressure and random refresh pulses shows whether the stalls really are confined to one bank and whether ordering survives reads that finish out of order across banks.

// File: rtl/ilv_mem_pkg.sv
package ilv_mem_pkg;
  typedef enum logic {
    ACC_MISS = 1'b0,
    ACC_HIT  = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/ilv_addr_map.sv
module ilv_addr_map #(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned COL_W   = 3,
  parameter int unsigned TAG_LSB = 7,
  localparam int unsigned LOC_W  = ADDR_W - BANK_W,
  localparam int unsigned ROW_W  = ADDR_W - BANK_W - COL_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              perm_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [LOC_W-1:0]  loc_o,
  output logic [ROW_W-1:0]  row_o
);
  logic [BANK_W-1:0] tag_slice;

  assign tag_slice = perm_i ? addr_i[TAG_LSB +: BANK_W] : '0;
  // tag slice sits inside the row bits, so a page never splits across banks
  assign bank_o    = addr_i[BANK_W-1:0] ^ tag_slice;
  assign loc_o     = addr_i[ADDR_W-1:BANK_W];
  assign row_o     = addr_i[ADDR_W-1:BANK_W+COL_W];
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank
  import ilv_mem_pkg::*;
#(
  parameter int unsigned LOC_W    = 8,
  parameter int unsigned ROW_W    = 5,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MISS_LAT = 4,
  parameter int unsigned REF_LAT  = 6,
  parameter int unsigned CNT_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [LOC_W-1:0]  loc_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  input  logic              ref_req_i,
  output logic              free_o,
  output logic              hit_o,
  output logic              data_rdy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              refreshing_o,
  output logic              open_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  localparam int unsigned MAX_LAT = (MISS_LAT > REF_LAT) ? MISS_LAT : REF_LAT;
  localparam int unsigned LAT_W   = $clog2(MAX_LAT + 1);
  localparam int unsigned DEPTH   = 1 << LOC_W;
  localparam logic [LAT_W-1:0] MISS_LD = LAT_W'(MISS_LAT - 1);
  localparam logic [LAT_W-1:0] REF_LD  = LAT_W'(REF_LAT);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic [LAT_W-1:0]  acc_cnt_q, ref_cnt_q;
  logic              ref_pend_q, open_q, slot_q;
  logic [ROW_W-1:0]  open_row_q;
  logic [CNT_W-1:0]  hit_q, miss_q;
  acc_kind_e         kind;
  logic              ref_start;

  assign kind      = (open_q && open_row_q == row_i) ? ACC_HIT : ACC_MISS;
  assign ref_start = ref_pend_q && acc_cnt_q == '0 && ref_cnt_q == '0;
  // a bank whose read slot drains this cycle may take a new request
  assign free_o    = acc_cnt_q == '0 && ref_cnt_q == '0 && !ref_pend_q &&
                     (!slot_q || pop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_cnt_q  <= '0;
      ref_cnt_q  <= '0;
      ref_pend_q <= 1'b0;
      open_q     <= 1'b0;
      open_row_q <= '0;
      slot_q     <= 1'b0;
      hit_q      <= '0;
      miss_q     <= '0;
    end else begin
      if (sel_i)                acc_cnt_q <= (kind == ACC_HIT) ? '0 : MISS_LD;
      else if (acc_cnt_q != '0) acc_cnt_q <= acc_cnt_q - 1'b1;

      if (ref_cnt_q != '0) ref_cnt_q <= ref_cnt_q - 1'b1;
      else if (ref_start)  ref_cnt_q <= REF_LD;
      ref_pend_q <= (ref_pend_q && !ref_start) || ref_req_i;

      if (ref_start) open_q <= 1'b0;
      else if (sel_i) begin
        open_q     <= 1'b1;
        open_row_q <= row_i;
      end

      if (sel_i && !we_i) slot_q <= 1'b1;
      else if (pop_i)     slot_q <= 1'b0;

      if (sel_i) begin
        if (kind == ACC_HIT) hit_q  <= hit_q + 1'b1;
        else                 miss_q <= miss_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (sel_i && we_i) mem[loc_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (sel_i && !we_i) rdata_q <= mem[loc_i];
  end

  assign hit_o        = (kind == ACC_HIT);
  assign data_rdy_o   = slot_q && acc_cnt_q == '0;
  assign rdata_o      = rdata_q;
  assign refreshing_o = ref_cnt_q != '0;
  assign open_o       = open_q;
  assign hit_cnt_o    = hit_q;
  assign miss_cnt_o   = miss_q;
endmodule

// File: rtl/ilv_order_fifo.sv
module ilv_order_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 2,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic          empty_o,
  output logic [PW:0]   count_o
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop_i)  rp_q <= rp_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) store[wp_q] <= din_i;
  end

  assign head_o  = store[rp_q];
  assign empty_o = cnt_q == '0;
  assign count_o = cnt_q;
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned N_BANKS  = 4,
  parameter int unsigned COL_W    = 3,
  parameter int unsigned TAG_LSB  = 7,
  parameter int unsigned MISS_LAT = 4,
  parameter int unsigned REF_LAT  = 6,
  parameter int unsigned CNT_W    = 16,
  localparam int unsigned BANK_W  = $clog2(N_BANKS),
  localparam int unsigned LOC_W   = ADDR_W - BANK_W,
  localparam int unsigned ROW_W   = ADDR_W - BANK_W - COL_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mode_perm_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic                     req_we_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  output logic                     rsp_valid_o,
  input  logic                     rsp_ready_i,
  output logic [DATA_W-1:0]        rsp_rdata_o,
  input  logic [N_BANKS-1:0]       refresh_req_i,
  output logic [N_BANKS*CNT_W-1:0] hit_cnt_o,
  output logic [N_BANKS*CNT_W-1:0] miss_cnt_o
);
  logic [BANK_W-1:0] map_bank;
  logic [LOC_W-1:0]  map_loc;
  logic [ROW_W-1:0]  map_row;
  logic              accept, rsp_fire;
  logic [BANK_W-1:0] ord_head;
  logic              ord_empty;
  logic [BANK_W:0]   ord_cnt;

  logic [N_BANKS-1:0] bank_sel, bank_pop, bank_free, bank_hit;
  logic [N_BANKS-1:0] bank_rdy, bank_refr, bank_open;
  logic [DATA_W-1:0]  bank_rdata [N_BANKS];

  ilv_addr_map #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .COL_W  (COL_W),
    .TAG_LSB(TAG_LSB)
  ) u_map (
    .addr_i(req_addr_i),
    .perm_i(mode_perm_i),
    .bank_o(map_bank),
    .loc_o (map_loc),
    .row_o (map_row)
  );

  assign req_ready_o = bank_free[map_bank];
  assign accept      = req_valid_i && req_ready_o;
  assign rsp_valid_o = !ord_empty && bank_rdy[ord_head];
  assign rsp_fire    = rsp_valid_o && rsp_ready_i;
  assign rsp_rdata_o = bank_rdata[ord_head];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign bank_sel[b] = accept && map_bank == BANK_W'(b);
    assign bank_pop[b] = rsp_fire && ord_head == BANK_W'(b);

    ilv_bank #(
      .LOC_W   (LOC_W),
      .ROW_W   (ROW_W),
      .DATA_W  (DATA_W),
      .MISS_LAT(MISS_LAT),
      .REF_LAT (REF_LAT),
      .CNT_W   (CNT_W)
    ) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_i       (bank_sel[b]),
      .we_i        (req_we_i),
      .loc_i       (map_loc),
      .row_i       (map_row),
      .wdata_i     (req_wdata_i),
      .pop_i       (bank_pop[b]),
      .ref_req_i   (refresh_req_i[b]),
      .free_o      (bank_free[b]),
      .hit_o       (bank_hit[b]),
      .data_rdy_o  (bank_rdy[b]),
      .rdata_o     (bank_rdata[b]),
      .refreshing_o(bank_refr[b]),
      .open_o      (bank_open[b]),
      .hit_cnt_o   (hit_cnt_o[b*CNT_W +: CNT_W]),
      .miss_cnt_o  (miss_cnt_o[b*CNT_W +: CNT_W])
    );
  end

  // one outstanding read per bank bounds the order queue at N_BANKS
  ilv_order_fifo #(
    .DEPTH(N_BANKS),
    .W    (BANK_W)
  ) u_order (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (accept && !req_we_i),
    .din_i  (map_bank),
    .pop_i  (rsp_fire),
    .head_o (ord_head),
    .empty_o(ord_empty),
    .count_o(ord_cnt)
  );
endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
module ilv_mem_ctrl_chk #(
  parameter int unsigned N_BANKS = 4,
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned BANK_W = $clog2(N_BANKS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rsp_valid_i,
  input logic               rsp_ready_i,
  input logic [DATA_W-1:0]  rsp_rdata_i,
  input logic [N_BANKS-1:0] sel_i,
  input logic [N_BANKS-1:0] hit_i,
  input logic [N_BANKS-1:0] free_i,
  input logic [N_BANKS-1:0] refr_i,
  input logic [N_BANKS-1:0] open_i,
  input logic [BANK_W:0]    ord_cnt_i
);
  AST_ORDER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ord_cnt_i <= (BANK_W+1)'(N_BANKS)); // R7

  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && !rsp_ready_i |=> rsp_valid_i && $stable(rsp_rdata_i)); // R7

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank_chk
    AST_NO_ACCESS_IN_REFRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_i[b] |-> !refr_i[b]); // R6

    AST_REFRESH_CLOSES_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      refr_i[b] |-> !open_i[b]); // R6

    AST_MISS_BLOCKS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_i[b] && !hit_i[b] |=> !free_i[b]); // R4

    AST_HIT_REOPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_i[b] |=> open_i[b]); // R3
  end
endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(
  .N_BANKS(N_BANKS),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rsp_valid_i(rsp_valid_o),
  .rsp_ready_i(rsp_ready_i),
  .rsp_rdata_i(rsp_rdata_o),
  .sel_i      (bank_sel),
  .hit_i      (bank_hit),
  .free_i     (bank_free),
  .refr_i     (bank_refr),
  .open_i     (bank_open),
  .ord_cnt_i  (ord_cnt)
);

// File: tb/ilv_mem_ctrl_tb.sv
module ilv_mem_ctrl_tb;
  localparam int NB = 4;
  localparam int MISS = 4;
  localparam int REFL = 6;
  localparam time CLK = 8ns;

  logic clk = 0, rst_ni = 0, mode = 0;
  logic req_valid = 0, req_we = 0, rsp_ready = 1;
  logic [9:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [NB-1:0] refr = '0;
  logic req_ready_o, rsp_valid_o;
  logic [15:0] rsp_rdata_o;
  logic [NB*16-1:0] hit_cnt_o, miss_cnt_o;

  always #(CLK/2) clk = ~clk;

  ilv_mem_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_perm_i(mode),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata_o),
    .refresh_req_i(refr), .hit_cnt_o(hit_cnt_o), .miss_cnt_o(miss_cnt_o)
  );

  int n_vec = 0, n_err = 0;
  bit done = 0, bp_en = 0, rnd_ref = 0, last_acc = 0;
  int waits = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  // reference model state
  int m_cnt[NB], m_ref[NB], m_row[NB], m_hit[NB], m_miss[NB];
  bit m_pend[NB], m_slot[NB], m_open[NB];
  logic [15:0] m_dat[NB];
  logic [15:0] m_mem[1024];
  int m_q[$];

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int f_bank(int a, bit p);
    return (a & 3) ^ (p ? ((a >> 7) & 3) : 0);
  endfunction

  function automatic int hc(int b); return int'(hit_cnt_o[b*16 +: 16]); endfunction
  function automatic int mc(int b); return int'(miss_cnt_o[b*16 +: 16]); endfunction

  function automatic bit m_rsp_v();
    return m_q.size() > 0 && m_slot[m_q[0]] && m_cnt[m_q[0]] == 0;
  endfunction

  task automatic tick();
    bit exp_v, pop, exp_rdy, start[NB];
    int b, hd;
    rsp_ready = bp_en ? lfsr[3] : 1'b1;
    if (rnd_ref && lfsr[9:5] == 5'd7) refr = 4'b0001 << lfsr[12:11];
    #1;
    exp_v = m_rsp_v();
    pop = exp_v && rsp_ready;
    hd = (m_q.size() > 0) ? m_q[0] : 0;
    b = f_bank(int'(req_addr), mode);
    exp_rdy = m_cnt[b] == 0 && m_ref[b] == 0 && !m_pend[b] && (!m_slot[b] || (pop && hd == b));
    chk(req_ready_o === exp_rdy, "R5", "req_ready", req_ready_o, exp_rdy);
    chk(rsp_valid_o === exp_v, "R7", "rsp_valid", rsp_valid_o, exp_v);
    if (exp_v) chk(rsp_rdata_o === m_dat[hd], "R7", "rsp_data", rsp_rdata_o, m_dat[hd]);
    last_acc = req_valid && exp_rdy;
    // advance the model by one edge
    for (int i = 0; i < NB; i++) start[i] = m_pend[i] && m_cnt[i] == 0 && m_ref[i] == 0;
    if (pop) begin m_slot[hd] = 0; void'(m_q.pop_front()); end
    for (int i = 0; i < NB; i++) begin
      if (m_ref[i] > 0) m_ref[i]--;
      else if (start[i]) begin m_ref[i] = REFL; m_open[i] = 0; end
      m_pend[i] = (m_pend[i] && !start[i]) || refr[i];
      if (m_cnt[i] > 0) m_cnt[i]--;
    end
    if (last_acc) begin
      int row = int'(req_addr) >> 5;
      bit hit = m_open[b] && m_row[b] == row;
      m_cnt[b] = hit ? 0 : MISS - 1;
      m_open[b] = 1; m_row[b] = row;
      if (hit) m_hit[b]++; else m_miss[b]++;
      if (req_we) m_mem[req_addr] = req_wdata;
      else begin m_slot[b] = 1; m_dat[b] = m_mem[req_addr]; m_q.push_back(b); end
    end
    @(posedge clk);
    lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
    @(negedge clk);
    refr = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_req(bit we, int a, logic [15:0] d);
    req_valid = 1; req_we = we; req_addr = 10'(a); req_wdata = d;
    waits = 0;
    tick();
    while (!last_acc) begin waits++; tick(); end
    req_valid = 0;
  endtask

  task automatic rd_lat(int a, output int n);
    do_req(0, a, '0);
    #1; n = 1;
    while (!rsp_valid_o && n < 20) begin tick(); #1; n++; end
  endtask

  initial begin
    int n, h, t[NB];
    for (int i = 0; i < NB; i++) begin
      m_cnt[i] = 0; m_ref[i] = 0; m_row[i] = 0; m_hit[i] = 0; m_miss[i] = 0;
      m_pend[i] = 0; m_slot[i] = 0; m_open[i] = 0; m_dat[i] = '0;
    end
    for (int i = 0; i < 1024; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    chk(req_ready_o === 1'b1, "R5", "reset ready", req_ready_o, 1);
    chk(rsp_valid_o === 1'b0, "R7", "reset rsp_valid", rsp_valid_o, 0);
    chk(hit_cnt_o === '0 && miss_cnt_o === '0, "R9", "reset counters", hit_cnt_o, 0);
    @(negedge clk);

    // R1: sequential writes rotate over banks
    for (int a = 0; a < 4; a++) do_req(1, a, 16'(a * 7 + 3));
    for (int b = 0; b < NB; b++)
      chk(mc(b) == 1 && hc(b) == 0, "R1", $sformatf("bank %0d after 0..3", b), mc(b), 1);
    for (int a = 4; a < 64; a++) do_req(1, a, 16'(a * 7 + 3));
    idle(4);

    // R4 then R3: isolated reads
    rd_lat(5, n);  chk(n == MISS, "R4", "miss latency", n, MISS);
    idle(2);
    rd_lat(9, n);  chk(n == 1, "R3", "hit latency", n, 1);
    idle(2);

    // R7: sequential read stream, free-flowing then with backpressure
    for (int a = 0; a < 64; a++) do_req(0, a, '0);
    bp_en = 1;
    for (int a = 63; a >= 0; a -= 3) do_req(0, a, '0);
    bp_en = 0;
    idle(10);

    // R8: read after write
    do_req(1, 100, 16'hBEEF);
    idle(4);
    rd_lat(100, n);
    chk(rsp_rdata_o === 16'hBEEF, "R8", "read after write", rsp_rdata_o, 16'hBEEF);
    idle(6);

    // R5: other bank proceeds, same bank stalls
    do_req(0, 0, '0);
    req_valid = 1; req_we = 0; req_addr = 10'd1;
    tick(); chk(last_acc, "R5", "other bank accepted", last_acc, 1);
    req_addr = 10'd4;
    tick(); chk(!last_acc, "R5", "busy bank held", last_acc, 0);
    req_valid = 0;
    do_req(0, 4, '0);
    idle(8);

    // R10: stride 128 in plain mode
    for (int k = 1; k < 4; k++) do_req(1, k * 128, 16'(k + 16'h500));
    idle(6);
    h = mc(0);
    for (int k = 0; k < 4; k++) do_req(0, k * 128, '0);
    idle(8);
    chk(mc(0) - h == 4, "R10", "plain stride bank0 misses", mc(0) - h, 4);

    // R10: stride 128 in permuted mode
    mode = 1;
    for (int k = 0; k < 4; k++) do_req(1, k * 128, 16'(k + 16'h600));
    idle(6);
    for (int b = 0; b < NB; b++) t[b] = hc(b) + mc(b);
    for (int k = 0; k < 4; k++) do_req(0, k * 128, '0);
    idle(8);
    for (int b = 0; b < NB; b++)
      chk(hc(b) + mc(b) - t[b] == 1, "R10", $sformatf("perm stride bank %0d", b), hc(b) + mc(b) - t[b], 1);

    // R2: same page stays in one bank and row
    h = hc(1);
    do_req(1, 'h84, 16'h0A84);
    do_req(0, 'h80, '0);
    idle(6);
    chk(hc(1) - h == 2, "R2", "page hits in bank1", hc(1) - h, 2);

    // R6: refresh blocks and closes the row
    h = mc(1);
    refr = 4'b0010; tick();
    do_req(0, 'h84, '0);
    chk(waits >= REFL, "R6", "stall cycles on refresh", waits, REFL);
    idle(8);
    chk(mc(1) - h == 1, "R6", "miss after refresh", mc(1) - h, 1);

    // fill memory, then random traffic with backpressure and refresh
    for (int a = 0; a < 1024; a++) do_req(1, a, 16'(a * 37 + 11));
    bp_en = 1; rnd_ref = 1;
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r = lfsr;
      do_req(r[20] & r[21], int'(r[30:21]), r[15:0]);
    end
    bp_en = 0; rnd_ref = 0;
    idle(30);

    for (int b = 0; b < NB; b++) begin
      chk(hc(b) == m_hit[b], "R9", $sformatf("hit count bank %0d", b), hc(b), m_hit[b]);
      chk(mc(b) == m_miss[b], "R9", $sformatf("miss count bank %0d", b), mc(b), m_miss[b]);
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    #(CLK * 150000);
    if (!done) begin
      done = 1;
      n_vec++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule